// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps an interrupt-enable word and an interrupt-status word for each of five localities and folds them into one shared interrupt pin. Event sources elsewhere in the chip report four kinds of event (data ready for reading, status now valid, a change of the owning locality, readiness for a new command). Each report carries a target locality. An event is latched into that locality's status word only when the locality has both its global enable and the matching source enable set. A latched event raises the shared line.

Software reaches the words through a simple register port. A write names a locality, a register select, four byte-lane strobes and a 32-bit value. Writes to the enable and status words are accepted only from the locality that currently owns the interface. The status word is write-one-to-clear. The line drops when a status clear leaves the writer's status word at zero. The vector register is a read-only constant. The pin's sense follows the polarity field of the locality that last raised the line.

Top module: `irq_enable_status_unit`

## Requirements
- R1: After reset every locality's enable word reads 0x00000008, its status word reads 0, and the pin is high (line inactive under the low-level polarity code 01).
- R2: An accepted enable write replaces, in each byte lane whose strobe is set, only the writable bits (mask 0x8000009F: bit 31 global, bits 4:3 polarity, bit 7 command-ready, bit 2 locality-change, bit 1 status-valid, bit 0 data-ready). Other bits keep their values.
- R3: Event input bits 0,1,2,3 (data-ready, status-valid, locality-change, command-ready) map to status bits 0,1,2,7. An event sets a status bit, and asserts the line, only when the target locality's bit 31 and that bit's enable are both set.
- R4: Events whose locality index is 5 or higher change no status word and do not raise the line.
- R5: An accepted status write clears each status bit that is written as one in a strobed lane within mask 0x00000087. Zeros and other bits have no effect.
- R6: The line is deasserted when an accepted status write clears at least one bit of a non-zero status word and leaves it zero. Otherwise a write leaves the line as it was. An event in the same cycle takes precedence.
- R7: Enable and status writes are ignored unless `own_valid` is high and `wr_loc` equals `own_loc`.
- R8: The vector register (select 1) reads the parameter `VEC_NUM` (0 to 15). Writes to it change nothing.
- R9: The pin equals the inverted line when the captured polarity is 01, and the line itself otherwise. The polarity is captured from the enable word of the locality whose event raised the line.
- R10: Register reads are combinational. Select codes: 0 enable, 2 status, 1 vector, 3 reads zero. A locality index of 5 or more reads zero. Writes and events take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_valid | input | 1 | A locality currently owns the interface |
| own_loc | input | 3 | Index of the owning locality |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | 3 | Locality issuing the write |
| wr_sel | input | 2 | Register select for the write |
| wr_be | input | 4 | Byte-lane strobes |
| wr_data | input | 32 | Write value |
| rd_loc | input | 3 | Locality for the read |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Read value |
| ev_en | input | 1 | Event report strobe |
| ev_loc | input | 3 | Target locality of the event |
| ev_bits | input | 4 | Event kinds {command-ready, locality-change, status-valid, data-ready} |
| irq_pin | output | 1 | Shared interrupt pin |

## Verification
For every locality the bench sweeps all 32 combinations of global and source enables, each against all 16 event-bit patterns. These runs separate gating by the global bit from gating by the source bits, and they check the event-to-status bit mapping. The enable polarity values vary across the same sweep, so the pin's sense is checked both while the line is raised and after it is cleared. All 16 byte-strobe patterns are applied to the enable word in both directions to confirm lane isolation and the writable mask. Separate runs send writes from non-owning localities, with no owner, and to the vector register, and they send events to the out-of-range indices 5 to 7.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  typedef enum logic [1:0] {
    RS_ENABLE = 2'd0,
    RS_VECTOR = 2'd1,
    RS_STATUS = 2'd2,
    RS_NONE   = 2'd3
  } rsel_e;

  localparam logic [31:0] EN_WR_MASK = 32'h8000_009F;
  localparam logic [31:0] ST_MASK    = 32'h0000_0087;
  localparam logic [31:0] EN_RESET   = 32'h0000_0008;
  localparam logic [1:0]  POL_LOW    = 2'b01;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] ev_to_bits(input logic [3:0] ev);
    return {24'd0, ev[3], 4'd0, ev[2], ev[1], ev[0]};
  endfunction

endpackage

// File: rtl/irq_loc_regs.sv
module irq_loc_regs
  import irq_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ev_bits,
  input  logic        en_wr,
  input  logic        st_wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] en_q,
  output logic [31:0] st_q,
  output logic        raise,
  output logic        zeroed
);

  logic [31:0] lm, hit, clr, st_left, en_next, st_next;

  always_comb begin
    lm      = lane_mask(be);
    hit     = en_q[31] ? (en_q & ev_to_bits(ev_bits)) : 32'd0;
    raise   = |hit;
    clr     = st_wr ? (wdata & lm & ST_MASK) : 32'd0;
    st_left = st_q & ~clr;
    zeroed  = (clr != 32'd0) && (st_q != 32'd0) && (st_left == 32'd0);
    st_next = st_left | hit;
    en_next = en_wr ? ((en_q & ~(lm & EN_WR_MASK)) | (wdata & lm & EN_WR_MASK))
                    : en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= 32'd0;
    end else begin
      en_q <= en_next;
      st_q <= st_next;
    end
  end

  AST_ST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~ST_MASK) == 32'd0); // R5
  AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~(EN_WR_MASK | EN_RESET)) == 32'd0); // R2
  AST_EVT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q)) != 32'd0) |-> $past(en_q[31])); // R3

endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
  import irq_unit_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LOC-1:0]      raise,
  input  logic [NUM_LOC-1:0]      zeroed,
  input  logic [NUM_LOC-1:0][1:0] pol_in,
  output logic                    irq_pin
);

  logic       line_q;
  logic [1:0] pol_q;
  logic [1:0] pol_pick;

  always_comb begin
    pol_pick = pol_q;
    for (int i = 0; i < NUM_LOC; i++)
      if (raise[i]) pol_pick = pol_in[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pol_q  <= POL_LOW;
    end else if (|raise) begin
      line_q <= 1'b1;
      pol_q  <= pol_pick;
    end else if (|zeroed) begin
      line_q <= 1'b0;
    end
  end

  assign irq_pin = (pol_q == POL_LOW) ? ~line_q : line_q;

  AST_LINE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> $past(|raise)); // R3
  AST_LINE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_q) |-> $past(|zeroed)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise) |=> line_q); // R6

endmodule

// File: rtl/irq_enable_status_unit.sv
module irq_enable_status_unit
  import irq_unit_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int VEC_NUM = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        own_valid,
  input  logic [2:0]  own_loc,
  input  logic        wr_en,
  input  logic [2:0]  wr_loc,
  input  logic [1:0]  wr_sel,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_loc,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        ev_en,
  input  logic [2:0]  ev_loc,
  input  logic [3:0]  ev_bits,
  output logic        irq_pin
);

  localparam logic [31:0] VEC_WORD = 32'(VEC_NUM);
  localparam int          LAST_LOC = NUM_LOC - 1;

  initial begin
    AST_VEC_RANGE: assert (VEC_NUM >= 0 && VEC_NUM <= 15 && LOC_W == 3); // R8
  end

  logic                      wr_ok, ev_ok;
  logic [NUM_LOC-1:0][31:0]  en_q, st_q;
  logic [NUM_LOC-1:0]        raise, zeroed;
  logic [NUM_LOC-1:0][1:0]   pol;

  assign wr_ok = wr_en && own_valid && (wr_loc == own_loc) && (32'(wr_loc) <= LAST_LOC);
  assign ev_ok = ev_en && (32'(ev_loc) <= LAST_LOC);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic       sel_me, ev_me;
    assign sel_me = wr_ok && (32'(wr_loc) == i);
    assign ev_me  = ev_ok && (32'(ev_loc) == i);

    irq_loc_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_bits(ev_me ? ev_bits : 4'd0),
      .en_wr  (sel_me && (rsel_e'(wr_sel) == RS_ENABLE)),
      .st_wr  (sel_me && (rsel_e'(wr_sel) == RS_STATUS)),
      .be     (wr_be),
      .wdata  (wr_data),
      .en_q   (en_q[i]),
      .st_q   (st_q[i]),
      .raise  (raise[i]),
      .zeroed (zeroed[i])
    );
    assign pol[i] = en_q[i][4:3];

    AST_EN_HOLD_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && own_valid && wr_loc == own_loc && 32'(wr_loc) == i)
        |=> $stable(en_q[i])); // R7
  end

  irq_line_ctl #(.NUM_LOC(NUM_LOC)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .raise  (raise),
    .zeroed (zeroed),
    .pol_in (pol),
    .irq_pin(irq_pin)
  );

  always_comb begin
    rd_data = 32'd0;
    if (32'(rd_loc) <= LAST_LOC) begin
      case (rsel_e'(rd_sel))
        RS_ENABLE: rd_data = en_q[rd_loc];
        RS_STATUS: rd_data = st_q[rd_loc];
        RS_VECTOR: rd_data = VEC_WORD;
        default:   rd_data = 32'd0;
      endcase
    end
  end

  AST_BAD_LOC_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en && 32'(ev_loc) > LAST_LOC && !wr_en) |=> $stable(st_q)); // R4

endmodule

// File: tb/tb_irq_enable_status_unit.sv
module tb_irq_enable_status_unit;

  localparam int CLK_PERIOD = 10;
  localparam int VEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        own_valid = 1'b0;
  logic [2:0]  own_loc = 3'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_loc = 3'd0;
  logic [1:0]  wr_sel = 2'd0;
  logic [3:0]  wr_be = 4'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_loc = 3'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        ev_en = 1'b0;
  logic [2:0]  ev_loc = 3'd0;
  logic [3:0]  ev_bits = 4'd0;
  logic        irq_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_en [5];
  logic [31:0] m_st [5];
  logic        m_line;
  logic [1:0]  m_pol;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_enable_status_unit #(.VEC_NUM(VEC)) dut (.*);

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m = 32'd0;
    for (int b = 0; b < 4; b++) if (be[b]) m = m | (32'hFF << (8*b));
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] l, input logic [1:0] s, output logic [31:0] v);
    rd_loc = l; rd_sel = s; #1; v = rd_data;
  endtask

  task automatic check_pin(input string req);
    logic e;
    e = (m_pol == 2'b01) ? !m_line : m_line;
    check(req, {31'd0, irq_pin}, {31'd0, e});
  endtask

  task automatic wr(input logic [2:0] l, input logic [1:0] s, input logic [3:0] be,
                    input logic [31:0] d);
    logic [31:0] lm, clr;
    @(negedge clk);
    wr_en = 1'b1; wr_loc = l; wr_sel = s; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    lm = lanes(be);
    if (own_valid && l == own_loc && l < 5) begin
      if (s == 2'd0) m_en[l] = (m_en[l] & ~(lm & 32'h8000009F)) | (d & lm & 32'h8000009F);
      if (s == 2'd2) begin
        clr = d & lm & 32'h87;
        if (clr != 0 && m_st[l] != 0 && (m_st[l] & ~clr) == 0) m_line = 1'b0;
        m_st[l] = m_st[l] & ~clr;
      end
    end
  endtask

  task automatic evt(input logic [2:0] l, input logic [3:0] b);
    logic [31:0] hit;
    @(negedge clk);
    ev_en = 1'b1; ev_loc = l; ev_bits = b;
    @(negedge clk);
    ev_en = 1'b0;
    if (l < 5 && m_en[l][31]) begin
      hit = m_en[l] & {24'd0, b[3], 4'd0, b[2], b[1], b[0]};
      m_st[l] = m_st[l] | hit;
      if (hit != 0) begin m_line = 1'b1; m_pol = m_en[l][4:3]; end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, prev;
    for (int i = 0; i < 5; i++) begin m_en[i] = 32'h8; m_st[i] = 0; end
    m_line = 0; m_pol = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), 2'd0, v); check("R1 enable reset", v, 32'h8);
      rd(3'(i), 2'd2, v); check("R1 status reset", v, 32'h0);
    end
    check("R1 pin reset", {31'd0, irq_pin}, 32'd1);

    // R8 vector read, write ignored; R10 select 3 and bad locality read zero
    own_valid = 1'b1; own_loc = 3'd1;
    wr(3'd1, 2'd1, 4'hF, 32'hFFFF_FFFF);
    rd(3'd1, 2'd1, v); check("R8 vector", v, 32'(VEC));
    rd(3'd1, 2'd3, v); check("R10 unused select", v, 32'd0);
    rd(3'd6, 2'd0, v); check("R10 bad locality read", v, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), 2'd0, v); check("R8 vector write no effect", v, m_en[i]);
    end

    // R2 byte-lane sweep both directions
    for (int be = 0; be < 16; be++) begin
      wr(3'd1, 2'd0, 4'hF, 32'h0);
      wr(3'd1, 2'd0, 4'(be), 32'hFFFF_FFFF);
      rd(3'd1, 2'd0, v); check("R2 lane set", v, lanes(4'(be)) & 32'h8000009F);
      wr(3'd1, 2'd0, 4'hF, 32'hFFFF_FFFF);
      wr(3'd1, 2'd0, 4'(be), 32'h0);
      rd(3'd1, 2'd0, v); check("R2 lane clear", v, ~lanes(4'(be)) & 32'h8000009F);
    end
    wr(3'd1, 2'd0, 4'hF, 32'h8);

    // R7 writes from non-owner and with no owner
    rd(3'd2, 2'd0, prev);
    wr(3'd2, 2'd0, 4'hF, 32'h8000_0087);
    rd(3'd2, 2'd0, v); check("R7 foreign enable write", v, prev);
    own_valid = 1'b0;
    wr(3'd1, 2'd0, 4'hF, 32'h8000_0087);
    rd(3'd1, 2'd0, v); check("R7 no owner enable write", v, 32'h8);
    own_valid = 1'b1;

    // R3/R5/R6/R9 sweep enables x events for every locality
    for (int l = 0; l < 5; l++) begin
      own_loc = 3'(l);
      for (int g = 0; g < 32; g++) begin
        logic [31:0] env;
        env = {g[4], 23'd0, g[3], 2'd0, g[0] ^ g[3], g[1], g[2], g[1], g[0]};
        for (int e = 0; e < 16; e++) begin
          wr(3'(l), 2'd0, 4'hF, env);
          wr(3'(l), 2'd2, 4'hF, 32'hFFFF_FFFF);
          rd(3'(l), 2'd2, v); check("R5 status cleared", v, m_st[l]);
          check_pin("R6 pin after clear");
          evt(3'(l), 4'(e));
          rd(3'(l), 2'd2, v); check("R3 status after event", v, m_st[l]);
          check_pin("R9 pin after event");
        end
      end
      // R7 foreign status clear ignored
      wr(3'(l), 2'd0, 4'hF, 32'h8000_0087);
      evt(3'(l), 4'hF);
      own_loc = 3'((l + 1) % 5);
      wr(3'(l), 2'd2, 4'hF, 32'hFFFF_FFFF);
      rd(3'(l), 2'd2, v); check("R7 foreign status clear", v, 32'h87);
      own_loc = 3'(l);
      // R5 partial clear, masked lane and line held
      wr(3'(l), 2'd2, 4'hE, 32'h0000_0087);
      rd(3'(l), 2'd2, v); check("R5 unstrobed lane", v, 32'h87);
      wr(3'(l), 2'd2, 4'h1, 32'h0000_0003);
      rd(3'(l), 2'd2, v); check("R5 partial clear", v, 32'h84);
      check_pin("R6 line held while nonzero");
      wr(3'(l), 2'd2, 4'h1, 32'h0000_0084);
      rd(3'(l), 2'd2, v); check("R5 full clear", v, 32'h0);
      check_pin("R6 line drops at zero");
    end

    // R4 events to invalid localities
    own_loc = 3'd0;
    for (int l = 0; l < 5; l++) begin
      own_loc = 3'(l);
      wr(3'(l), 2'd0, 4'hF, 32'h8000_0097);
    end
    for (int l = 5; l < 8; l++) begin
      evt(3'(l), 4'hF);
      for (int i = 0; i < 5; i++) begin
        rd(3'(i), 2'd2, v); check("R4 bad locality event", v, 32'h0);
      end
      check_pin("R4 pin unchanged");
    end
    finish_run();
  end

endmodule